// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management side of an Ethernet PHY at register level. A MAC hands it one 32-bit management frame word per operation. The word carries a direction bit, a 10-bit combined address that selects a PHY and a register within it, and a 16-bit data field. A read places the selected register value in the low half of the frame register. A write updates the control, advertisement or interrupt-mask register through a fixed bit mask. Every operation, read or write, produces a one-cycle done event that the MAC can fold into its own event flags. There is no serial bit timing. Autonegotiation finishes in the same cycle that it is requested.

A `link_up` level input stands in for the line. Its rising and falling edges update the link and autonegotiation bits of the status register. They also latch event bits in an interrupt-source register, which clears when it is read. Commands arrive on a valid/ready input. `cmd_ready` is held high, so the block never applies back-pressure, and a command is taken in every cycle in which `cmd_valid` is high. Results appear on `frame_word` and `mii_done` one clock edge after acceptance. `frame_word` holds its value until the next accepted command.

Top module: `phy_mgmt_top`

## Requirements
- R1: A command is accepted on each rising clock edge where `cmd_valid` is high (`cmd_ready` is always high). In the command word, bit 29 set means read and bit 29 clear means write. Bits 27:23 are the PHY number, bits 22:18 the register number and bits 15:0 the write data.
- R2: After reset, control (register 0) reads 0x3000, status (register 1) reads 0x7809, advertisement (register 4) reads 0x01E1, and interrupt source (register 29) and interrupt mask (register 30) read 0. `frame_word` is 0 and `mii_done` is low.
- R3: A control write stores the data ANDed with 0x7980. If data bit 12 (autonegotiation enable) is set, status bit 5 is set at once. Clearing bit 12 later does not clear status bit 5.
- R4: An advertisement write stores (data AND 0x2D7F) OR 0x0080. An interrupt-mask write stores data AND 0x00FF.
- R5: A rising edge of `link_up` sets status bits 2 and 5 and latches interrupt-source bits 7 and 6. A falling edge clears status bits 2 and 5 and latches interrupt-source bit 4.
- R6: A read of register 29 returns the latched bits and clears them. A link event in the same cycle as that read is still latched after the read.
- R7: If the PHY number does not equal the configured PHY address, a read returns 0 and does not clear the interrupt source, and a write changes no register.
- R8: Reads of registers 5, 6 and of every register other than 0, 1, 4, 29 and 30 return 0. Writes to any register other than 0, 4 and 30 have no effect.
- R9: One edge after a read is accepted, `frame_word` holds command bits 31:16 above the read value. One edge after a write is accepted, it holds the whole command word. Without an accepted command it keeps its value.
- R10: `mii_done` is high for exactly the one cycle following each accepted command, whether read or write and whether or not the PHY number matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Management command present |
| cmd_ready | output | 1 | Always high; a command is taken whenever valid |
| cmd_word | input | 32 | Management frame word |
| frame_word | output | 32 | Frame register: last command with read result in bits 15:0 |
| mii_done | output | 1 | One-cycle pulse after each accepted command |
| link_up | input | 1 | Line state; edges drive status and interrupt events |

## Verification
The assertions check four things on every cycle: the done pulse follows each accepted command, write commands are echoed into `frame_word`, the upper half of the frame word is kept on reads, and `frame_word` stays put between commands. They also check that reads of a foreign PHY number, or of registers 5 and 6, yield zero. The write masks, the reset values, the latching and clearing of interrupt-source bits on link edges, and the status bits that follow the link can only be seen through sequences of commands. The bench's scenarios cover these, including a link edge that lands in the same cycle as a clearing read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned PHY_W   = 5;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned ADDR_W  = PHY_W + REG_W;
  localparam int unsigned INT_W   = 8;

  localparam int unsigned OP_BIT    = 29;
  localparam int unsigned ADDR_LSB  = 18;
  localparam int unsigned ADDR_MSB  = ADDR_LSB + ADDR_W - 1;

  localparam logic [REG_W-1:0] REG_CTRL   = 5'd0;
  localparam logic [REG_W-1:0] REG_STAT   = 5'd1;
  localparam logic [REG_W-1:0] REG_ADV    = 5'd4;
  localparam logic [REG_W-1:0] REG_LPA    = 5'd5;
  localparam logic [REG_W-1:0] REG_EXP    = 5'd6;
  localparam logic [REG_W-1:0] REG_ISRC   = 5'd29;
  localparam logic [REG_W-1:0] REG_IMASK  = 5'd30;

  localparam logic [DATA_W-1:0] CTRL_RST    = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_RST    = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST     = 16'h01E1;
  localparam logic [DATA_W-1:0] CTRL_KEEP   = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_KEEP    = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE   = 16'h0080;
  localparam logic [DATA_W-1:0] STAT_LINK   = 16'h0024;
  localparam logic [DATA_W-1:0] STAT_ANDONE = 16'h0020;
  localparam int unsigned       CTRL_ANEN_BIT = 12;

  localparam logic [INT_W-1:0] EVT_UP   = 8'hC0;
  localparam logic [INT_W-1:0] EVT_DOWN = 8'h10;

  typedef struct packed {
    logic              is_read;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regno;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;

endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phy_mgmt_pkg::*;
#(
  parameter logic [PHY_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              op_bit,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [DATA_W-1:0] data_field,
  output mgmt_cmd_t         cmd,
  output logic              phy_hit
);

  always_comb begin
    cmd.is_read = op_bit;
    cmd.phy     = addr_field[ADDR_W-1:REG_W];
    cmd.regno   = addr_field[REG_W-1:0];
    cmd.data    = data_field;
    phy_hit     = (addr_field[ADDR_W-1:REG_W] == PHY_ADDR);
  end

endmodule

// File: rtl/phy_link_monitor.sv
module phy_link_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  output logic link_rise,
  output logic link_fall
);

  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  assign link_rise = link_up & ~link_q;
  assign link_fall = ~link_up & link_q;

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  mgmt_cmd_t         cmd,
  input  logic              phy_hit,
  input  logic              link_rise,
  input  logic              link_fall,
  output logic [DATA_W-1:0] rd_value
);

  logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
  logic [INT_W-1:0]  isrc_q, imask_q;
  logic [DATA_W-1:0] stat_d;
  logic [INT_W-1:0]  isrc_d;
  logic              wr_en, rd_en;

  assign wr_en = fire & ~cmd.is_read & phy_hit;
  assign rd_en = fire &  cmd.is_read & phy_hit;

  always_comb begin
    stat_d = stat_q;
    if (link_rise) stat_d = stat_d | STAT_LINK;
    if (link_fall) stat_d = stat_d & ~STAT_LINK;
    if (wr_en && cmd.regno == REG_CTRL && cmd.data[CTRL_ANEN_BIT])
      stat_d = stat_d | STAT_ANDONE;
  end

  always_comb begin
    isrc_d = (rd_en && cmd.regno == REG_ISRC) ? '0 : isrc_q;
    if (link_rise) isrc_d = isrc_d | EVT_UP;
    if (link_fall) isrc_d = isrc_d | EVT_DOWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      stat_q  <= STAT_RST;
      adv_q   <= ADV_RST;
      isrc_q  <= '0;
      imask_q <= '0;
    end else begin
      stat_q <= stat_d;
      isrc_q <= isrc_d;
      if (wr_en) begin
        case (cmd.regno)
          REG_CTRL:  ctrl_q  <= cmd.data & CTRL_KEEP;
          REG_ADV:   adv_q   <= (cmd.data & ADV_KEEP) | ADV_FORCE;
          REG_IMASK: imask_q <= cmd.data[INT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_value = '0;
    if (phy_hit) begin
      case (cmd.regno)
        REG_CTRL:  rd_value = ctrl_q;
        REG_STAT:  rd_value = stat_q;
        REG_ADV:   rd_value = adv_q;
        REG_LPA:   rd_value = '0;
        REG_EXP:   rd_value = '0;
        REG_ISRC:  rd_value = {{(DATA_W-INT_W){1'b0}}, isrc_q};
        REG_IMASK: rd_value = {{(DATA_W-INT_W){1'b0}}, imask_q};
        default:   rd_value = '0;
      endcase
    end
  end

endmodule

// File: rtl/phy_frame_reg.sv
module phy_frame_reg
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_read,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [DATA_W-1:0] rd_value,
  output logic [WORD_W-1:0] frame_word,
  output logic              done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_word <= '0;
      done       <= 1'b0;
    end else begin
      done <= fire;
      if (fire) begin
        if (is_read) frame_word <= {cmd_word[WORD_W-1:DATA_W], rd_value};
        else         frame_word <= cmd_word;
      end
    end
  end

endmodule

// File: rtl/phy_mgmt_top.sv
module phy_mgmt_top
  import phy_mgmt_pkg::*;
#(
  parameter logic [PHY_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [WORD_W-1:0] frame_word,
  output logic              mii_done,
  input  logic              link_up
);

  mgmt_cmd_t         cmd;
  logic              phy_hit;
  logic              fire;
  logic              link_rise, link_fall;
  logic [DATA_W-1:0] rd_value;

  assign cmd_ready = 1'b1;
  assign fire      = cmd_valid & cmd_ready;

  phy_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .op_bit     (cmd_word[OP_BIT]),
    .addr_field (cmd_word[ADDR_MSB:ADDR_LSB]),
    .data_field (cmd_word[DATA_W-1:0]),
    .cmd        (cmd),
    .phy_hit    (phy_hit)
  );

  phy_link_monitor u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .link_rise (link_rise),
    .link_fall (link_fall)
  );

  phy_reg_bank u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .cmd       (cmd),
    .phy_hit   (phy_hit),
    .link_rise (link_rise),
    .link_fall (link_fall),
    .rd_value  (rd_value)
  );

  phy_frame_reg u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .is_read    (cmd.is_read),
    .cmd_word   (cmd_word),
    .rd_value   (rd_value),
    .frame_word (frame_word),
    .done       (mii_done)
  );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
  import phy_mgmt_pkg::*;
#(
  parameter logic [PHY_W-1:0] PHY_ADDR = 5'd1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [WORD_W-1:0] cmd_word,
  input logic [WORD_W-1:0] frame_word,
  input logic              mii_done
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R10: done pulse follows every accepted command
  a_r10_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> mii_done);

  // R10: no done without a command
  a_r10_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !mii_done);

  // R9: write echoes whole command word
  a_r9_write_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cmd_word[OP_BIT]) |=> frame_word == $past(cmd_word));

  // R9: read keeps upper half of command word
  a_r9_read_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word[OP_BIT]) |=> frame_word[WORD_W-1:DATA_W] == $past(cmd_word[WORD_W-1:DATA_W]));

  // R9: frame register holds between commands
  a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(frame_word));

  // R7: foreign PHY number reads zero
  a_r7_foreign_phy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word[OP_BIT] && cmd_word[ADDR_MSB:ADDR_LSB+REG_W] != PHY_ADDR)
      |=> frame_word[DATA_W-1:0] == '0);

  // R8: partner ability and expansion read zero
  a_r8_lpa_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_word[OP_BIT] &&
     (cmd_word[ADDR_LSB+REG_W-1:ADDR_LSB] == REG_LPA ||
      cmd_word[ADDR_LSB+REG_W-1:ADDR_LSB] == REG_EXP))
      |=> frame_word[DATA_W-1:0] == '0);

endmodule

bind phy_mgmt_top phy_mgmt_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_word   (cmd_word),
  .frame_word (frame_word),
  .mii_done   (mii_done)
);

// File: tb/phy_mgmt_top_test.sv
`timescale 1ns/1ps
module phy_mgmt_top_test;

  localparam logic [4:0] MY_PHY = 5'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic [31:0] frame_word;
  logic        mii_done;
  logic        link_up = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  phy_mgmt_top #(.PHY_ADDR(MY_PHY)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .frame_word(frame_word), .mii_done(mii_done),
    .link_up(link_up)
  );

  function automatic logic [31:0] mk(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    return {2'b01, rd, 1'b0, phy, rg, 2'b10, d};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] phy, logic [4:0] rg, logic [15:0] exp);
    op(mk(1'b1, phy, rg, 16'h0000));
    chk(tag, {16'h0, frame_word[15:0]}, {16'h0, exp});
  endtask

  task automatic wr(logic [4:0] rg, logic [15:0] d);
    op(mk(1'b0, MY_PHY, rg, d));
  endtask

  task automatic set_link(logic v);
    @(negedge clk);
    link_up = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 frame after reset", frame_word, 32'h0);
    chk("R2 done after reset", {31'h0, mii_done}, 32'h0);
    chk("R1 ready high", {31'h0, cmd_ready}, 32'h1);
    rd_chk("R2 control reset", MY_PHY, 5'd0, 16'h3000);
    rd_chk("R2 status reset", MY_PHY, 5'd1, 16'h7809);
    rd_chk("R2 advert reset", MY_PHY, 5'd4, 16'h01E1);
    rd_chk("R2 isrc reset", MY_PHY, 5'd29, 16'h0000);
    rd_chk("R2 imask reset", MY_PHY, 5'd30, 16'h0000);
  endtask

  task automatic t_frame;
    logic [31:0] w;
    w = mk(1'b0, MY_PHY, 5'd31, 16'hBEEF);
    op(w);
    chk("R9 write echo", frame_word, w);
    chk("R10 done after write", {31'h0, mii_done}, 32'h1);
    @(negedge clk);
    chk("R10 done one cycle", {31'h0, mii_done}, 32'h0);
    chk("R9 frame holds", frame_word, w);
    w = mk(1'b1, MY_PHY, 5'd2, 16'h1234);
    op(w);
    chk("R9 read frame", frame_word, {w[31:16], 16'h0000});
    chk("R10 done after read", {31'h0, mii_done}, 32'h1);
  endtask

  task automatic t_ctrl;
    wr(5'd0, 16'hFFFF);
    rd_chk("R3 control mask", MY_PHY, 5'd0, 16'h7980);
    rd_chk("R3 autoneg done set", MY_PHY, 5'd1, 16'h7829);
    wr(5'd0, 16'h0000);
    rd_chk("R3 control cleared", MY_PHY, 5'd0, 16'h0000);
    rd_chk("R3 autoneg done sticky", MY_PHY, 5'd1, 16'h7829);
  endtask

  task automatic t_adv_mask;
    wr(5'd4, 16'h0000);
    rd_chk("R4 advert forced bit", MY_PHY, 5'd4, 16'h0080);
    wr(5'd4, 16'hFFFF);
    rd_chk("R4 advert mask", MY_PHY, 5'd4, 16'h2DFF);
    wr(5'd30, 16'h1234);
    rd_chk("R4 imask low byte", MY_PHY, 5'd30, 16'h0034);
    wr(5'd30, 16'hFFFF);
    rd_chk("R4 imask full byte", MY_PHY, 5'd30, 16'h00FF);
  endtask

  task automatic t_link;
    set_link(1'b1);
    rd_chk("R5 status link up", MY_PHY, 5'd1, 16'h782D);
    rd_chk("R5 isrc up events", MY_PHY, 5'd29, 16'h00C0);
    rd_chk("R6 isrc cleared by read", MY_PHY, 5'd29, 16'h0000);
    set_link(1'b0);
    rd_chk("R5 status link down", MY_PHY, 5'd1, 16'h7809);
    rd_chk("R5 isrc down event", MY_PHY, 5'd29, 16'h0010);
    rd_chk("R6 isrc cleared again", MY_PHY, 5'd29, 16'h0000);
  endtask

  task automatic t_foreign;
    set_link(1'b1);
    rd_chk("R7 foreign read zero", 5'd0, 5'd29, 16'h0000);
    rd_chk("R7 foreign ctrl zero", 5'd2, 5'd0, 16'h0000);
    op(mk(1'b0, 5'd0, 5'd0, 16'h1000));
    rd_chk("R7 foreign write ignored", MY_PHY, 5'd0, 16'h0000);
    rd_chk("R7 isrc not cleared", MY_PHY, 5'd29, 16'h00C0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = mk(1'b1, MY_PHY, 5'd29, 16'h0);
    link_up   = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 read during event", {16'h0, frame_word[15:0]}, 32'h0);
    rd_chk("R6 event kept", MY_PHY, 5'd29, 16'h0010);
    rd_chk("R5 status after down", MY_PHY, 5'd1, 16'h7809);
  endtask

  task automatic t_unimpl;
    rd_chk("R8 reg5 zero", MY_PHY, 5'd5, 16'h0);
    rd_chk("R8 reg6 zero", MY_PHY, 5'd6, 16'h0);
    rd_chk("R8 reg3 zero", MY_PHY, 5'd3, 16'h0);
    rd_chk("R8 reg31 zero", MY_PHY, 5'd31, 16'h0);
    wr(5'd1, 16'hFFFF);
    rd_chk("R8 status write ignored", MY_PHY, 5'd1, 16'h7809);
    wr(5'd29, 16'h00FF);
    rd_chk("R8 isrc write ignored", MY_PHY, 5'd29, 16'h0);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_frame();
    t_ctrl();
    t_adv_mask();
    t_link();
    t_foreign();
    t_same_cycle();
    t_unimpl();
    finished = 1'b1;
    summary();
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule